// File: doc/BRIEF.md
# Recirculating Shift-Register Character Store

This block keeps the character codes of a text screen in a loop of shift registers rather than in addressable RAM. Every character code is spread over parallel one-bit tracks, one track per code bit. All tracks advance together once per clock, so one whole character passes the output tap each cycle. The tap is fed back into the head of the loop, so stored text is held for as long as the clock runs. A frame is 25 rows of 72 columns, which is 1800 characters. Each track is a chain of nine equal sections.

The video side receives the characters in row-major order, together with a valid strobe, a start-of-row flag and a start-of-frame flag. A host can post one write request at a time. The request gives a screen row, a column and a code. The block waits until that screen cell reaches the tap, puts the new code into the loop in place of the circulating one, and returns a one-cycle acknowledge. A scroll request moves the whole picture up one text row without copying any data. At the end of the current frame, video output is held off for one row's worth of shifts while the loop keeps turning. The next frame therefore starts one row further along the stream.

Top module: `ring_display_buffer`

## Requirements
- R1: After reset the loop runs one full lap of 1800 cycles and fills every cell with code 0 (blank). During that lap `vid_valid` and `wr_ack` stay low. `vid_valid` first goes high 1800 clock edges after reset is released, and the first frame shows 0 in every cell.
- R2: A frame is 1800 consecutive valid characters in row-major order. Frame index `row*72+col` carries cell (row, col). `vid_sof` is high with the character at index 0 only. `vid_sor` is high with every character whose index is a multiple of 72, so it is high 25 times per frame.
- R3: A cell that is not written keeps its code from frame to frame without limit.
- R4: A request (`wr_req` high for one cycle, with row < 25 and col < 72) is stored. Its code appears at frame index `row*72+col` in every later frame. `wr_ack` is high for exactly one cycle, no more than 1802 cycles after the request.
- R5: A request with row >= 25 or col >= 72 is dropped. No acknowledge follows and no cell changes.
- R6: While a request is waiting, a new `wr_req` is dropped. Only the waiting request is written and acknowledged.
- R7: A `scroll_req` pulse takes effect after the last character of the frame in progress, or of the next frame if the pulse comes with that last character. `vid_valid` is then low for exactly 72 cycles, and the next valid character carries `vid_sof`. The new frame shows old row r+1 in row r, and old row 0 wraps around to row 24.
- R8: Write coordinates refer to the screen as it is currently shown. After a scroll, a write to (0,0) changes the first character of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and control clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| wr_req | input | 1 | One-cycle pulse that posts a write request |
| wr_row | input | 5 | Screen row of the request |
| wr_col | input | 7 | Screen column of the request |
| wr_code | input | 6 | Character code to store |
| wr_ack | output | 1 | One-cycle pulse when the requested cell has been replaced |
| scroll_req | input | 1 | One-cycle pulse that requests a one-row scroll |
| vid_char | output | 6 | Character at the output tap |
| vid_valid | output | 1 | `vid_char` belongs to the frame being shown |
| vid_sof | output | 1 | First character of a frame |
| vid_sor | output | 1 | First character of a text row |

## Verification
A wrong position counter or frame offset puts characters in the wrong cells, and this shows up within one frame: a written code lands at the wrong index, or the row flags drift away from multiples of 72. A wrong insertion path or a wrong loop length damages the loop in a way that only shows one lap later. For that reason the bench reads back whole frames after each change and compares them against a screen model kept in the bench. Scroll faults appear within two frames, as a pause that is not exactly 72 cycles or as rows that are not shifted by one.

// File: rtl/ring_pkg.sv
package ring_pkg;

  // (a + b) mod depth, for 0 <= a, b < depth
  function automatic int wrap_add(input int a, input int b, input int depth);
    int s;
    s = a + b;
    return (s >= depth) ? s - depth : s;
  endfunction

  // (a - b) mod depth, for 0 <= a, b < depth
  function automatic int wrap_sub(input int a, input int b, input int depth);
    return (a >= b) ? a - b : a + depth - b;
  endfunction

  // row-major screen index of a cell
  function automatic int cell_index(input int row, input int col, input int cols);
    return row * cols + col;
  endfunction

endpackage

// File: rtl/ring_section.sv
module ring_section #(
  parameter int LEN = 200
) (
  input  logic clk,
  input  logic din,
  output logic dout
);
  logic [LEN-1:0] stage;

  always_ff @(posedge clk) begin
    stage <= {stage[LEN-2:0], din};
  end

  assign dout = stage[LEN-1];
endmodule

// File: rtl/ring_track.sv
module ring_track #(
  parameter int SECTIONS = 9,
  parameter int SEC_LEN  = 200
) (
  input  logic clk,
  input  logic din,
  output logic tap
);
  logic [SECTIONS:0] link;

  assign link[0] = din;

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    ring_section #(.LEN(SEC_LEN)) u_sec (
      .clk  (clk),
      .din  (link[s]),
      .dout (link[s+1])
    );
  end

  assign tap = link[SECTIONS];
endmodule

// File: rtl/ring_timing.sv
module ring_timing
  import ring_pkg::*;
#(
  parameter int ROWS = 25,
  parameter int COLS = 72,
  localparam int DEPTH  = ROWS * COLS,
  localparam int POS_W  = $clog2(DEPTH),
  localparam int HOLD_W = $clog2(COLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scroll_req,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] offset,
  output logic             init_busy,
  output logic             vid_valid,
  output logic             vid_sof,
  output logic             vid_sor
);
  logic [POS_W-1:0]  pos_q, off_q, disp_idx;
  logic [HOLD_W-1:0] hold_q;
  logic              init_q, scroll_pend_q;
  logic              lap_end, frame_end, scroll_apply;

  assign lap_end      = (pos_q == POS_W'(DEPTH - 1));
  assign disp_idx     = POS_W'(wrap_sub(int'(pos_q), int'(off_q), DEPTH));
  assign vid_valid    = !init_q && (hold_q == '0);
  assign frame_end    = vid_valid && (disp_idx == POS_W'(DEPTH - 1));
  assign scroll_apply = frame_end && scroll_pend_q;
  assign vid_sof      = vid_valid && (disp_idx == '0);
  assign vid_sor      = vid_valid && ((int'(disp_idx) % COLS) == 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q         <= '0;
      off_q         <= '0;
      init_q        <= 1'b1;
      scroll_pend_q <= 1'b0;
      hold_q        <= '0;
    end else begin
      pos_q <= lap_end ? '0 : pos_q + 1'b1;
      if (init_q && lap_end) init_q <= 1'b0;
      scroll_pend_q <= scroll_apply ? scroll_req : (scroll_pend_q | scroll_req);
      if (scroll_apply) begin
        off_q  <= POS_W'(wrap_add(int'(off_q), COLS, DEPTH));
        hold_q <= HOLD_W'(COLS);
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end
    end
  end

  assign pos       = pos_q;
  assign offset    = off_q;
  assign init_busy = init_q;

  // checker counter: consecutive cycles without video after the fill lap
  logic [HOLD_W:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   gap_q <= '0;
    else if (init_q || vid_valid) gap_q <= '0;
    else                          gap_q <= gap_q + 1'b1;
  end

  assert_fill_lap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_q) |-> (pos_q == '0));
  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!vid_valid || vid_sof));
  assert_offset_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q != $past(off_q)) |-> (int'(off_q) == wrap_add(int'($past(off_q)), COLS, DEPTH)));
  assert_gap_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gap_q) <= COLS);
endmodule

// File: rtl/ring_writer.sv
module ring_writer
  import ring_pkg::*;
#(
  parameter int ROWS = 25,
  parameter int COLS = 72,
  parameter int BITS = 6,
  localparam int DEPTH = ROWS * COLS,
  localparam int POS_W = $clog2(DEPTH),
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COL_W-1:0] wr_col,
  input  logic [BITS-1:0]  wr_code,
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] offset,
  input  logic             init_busy,
  output logic             hit,
  output logic [BITS-1:0]  ins_code,
  output logic             wr_ack
);
  logic             pend_q, ack_q, in_range;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [BITS-1:0]  code_q;
  logic [POS_W-1:0] target;

  assign in_range = (int'(wr_row) < ROWS) && (int'(wr_col) < COLS);
  assign target   = POS_W'(wrap_add(int'(offset),
                                    cell_index(int'(row_q), int'(col_q), COLS), DEPTH));
  assign hit      = pend_q && !init_busy && (pos == target);
  assign ins_code = code_q;
  assign wr_ack   = ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      code_q <= '0;
    end else begin
      ack_q <= hit;
      if (!pend_q && wr_req && in_range) begin
        pend_q <= 1'b1;
        row_q  <= wr_row;
        col_q  <= wr_col;
        code_q <= wr_code;
      end else if (hit) begin
        pend_q <= 1'b0;
      end
    end
  end

  assert_ack_not_in_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> !$past(init_busy));
  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> !wr_ack);
  assert_ack_after_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> $past(pend_q));
  assert_pending_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !hit) |=> (pend_q && $stable(row_q) && $stable(col_q) && $stable(code_q)));
endmodule

// File: rtl/ring_display_buffer.sv
module ring_display_buffer #(
  parameter int ROWS     = 25,
  parameter int COLS     = 72,
  parameter int BITS     = 6,
  parameter int SECTIONS = 9,
  localparam int DEPTH   = ROWS * COLS,
  localparam int SEC_LEN = DEPTH / SECTIONS,
  localparam int POS_W   = $clog2(DEPTH),
  localparam int ROW_W   = $clog2(ROWS),
  localparam int COL_W   = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [COL_W-1:0] wr_col,
  input  logic [BITS-1:0]  wr_code,
  output logic             wr_ack,
  input  logic             scroll_req,
  output logic [BITS-1:0]  vid_char,
  output logic             vid_valid,
  output logic             vid_sof,
  output logic             vid_sor
);
  logic [POS_W-1:0] pos, offset;
  logic             init_busy, hit;
  logic [BITS-1:0]  ins_code, tap_char, feed;

  ring_timing #(.ROWS(ROWS), .COLS(COLS)) u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .scroll_req (scroll_req),
    .pos        (pos),
    .offset     (offset),
    .init_busy  (init_busy),
    .vid_valid  (vid_valid),
    .vid_sof    (vid_sof),
    .vid_sor    (vid_sor)
  );

  ring_writer #(.ROWS(ROWS), .COLS(COLS), .BITS(BITS)) u_writer (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_req),
    .wr_row    (wr_row),
    .wr_col    (wr_col),
    .wr_code   (wr_code),
    .pos       (pos),
    .offset    (offset),
    .init_busy (init_busy),
    .hit       (hit),
    .ins_code  (ins_code),
    .wr_ack    (wr_ack)
  );

  // head of the loop: blank during the fill lap, new code on a hit,
  // otherwise the character leaving the tap goes round again
  always_comb begin
    if (init_busy) feed = '0;
    else if (hit)  feed = ins_code;
    else           feed = tap_char;
  end

  for (genvar b = 0; b < BITS; b++) begin : g_track
    ring_track #(.SECTIONS(SECTIONS), .SEC_LEN(SEC_LEN)) u_track (
      .clk (clk),
      .din (feed[b]),
      .tap (tap_char[b])
    );
  end

  assign vid_char = tap_char;
endmodule

// File: tb/ring_display_buffer_bench.sv
module ring_display_buffer_bench;
  localparam int ROWS = 25, COLS = 72, DEPTH = ROWS * COLS, NVEC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_req = 1'b0, scroll_req = 1'b0;
  logic [4:0] wr_row = '0;
  logic [6:0] wr_col = '0;
  logic [5:0] wr_code = '0;
  logic       wr_ack, vid_valid, vid_sof, vid_sor;
  logic [5:0] vid_char;

  int total = 0, bad = 0;
  int shot [DEPTH];
  int prev [DEPTH];
  int model [DEPTH];
  int sor_seen, sor_wrong;

  always #5 clk = ~clk;

  ring_display_buffer u_ring_display_buffer (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_row(wr_row), .wr_col(wr_col),
    .wr_code(wr_code), .wr_ack(wr_ack), .scroll_req(scroll_req), .vid_char(vid_char),
    .vid_valid(vid_valid), .vid_sof(vid_sof), .vid_sor(vid_sor)
  );

  // {expect_ack, row(5), col(7), code(6)}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 5'd0,  7'd0,  6'd1}, {1'b1, 5'd0,  7'd71, 6'd2},
    {1'b1, 5'd24, 7'd0,  6'd3}, {1'b1, 5'd24, 7'd71, 6'd4},
    {1'b1, 5'd12, 7'd35, 6'd5}, {1'b1, 5'd1,  7'd0,  6'd6},
    {1'b0, 5'd25, 7'd0,  6'd7}, {1'b0, 5'd3,  7'd72, 6'd8}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic grab_frame();
    int idx;
    int guard;
    guard = 0;
    while (!(vid_valid && vid_sof) && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    idx = 0; sor_seen = 0; sor_wrong = 0;
    while (idx < DEPTH && guard < 8000) begin
      if (vid_valid) begin
        shot[idx] = int'(vid_char);
        if (vid_sor) sor_seen++;
        if (vid_sor != ((idx % COLS) == 0)) sor_wrong++;
        if (vid_sof != (idx == 0)) sor_wrong++;
        idx++;
      end
      if (idx < DEPTH) @(negedge clk);
      guard++;
    end
  endtask

  task automatic do_write(input int row, input int col, input int code,
                          output int got, output int lat);
    @(negedge clk);
    wr_req = 1'b1; wr_row = 5'(row); wr_col = 7'(col); wr_code = 6'(code);
    @(negedge clk);
    wr_req = 1'b0;
    got = 0; lat = 1;
    while (lat < 1900) begin
      if (wr_ack) begin got++; break; end
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic count_diffs(output int n);
    n = 0;
    for (int i = 0; i < DEPTH; i++) if (shot[i] != model[i]) n++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, got, lat, acks;
    for (int i = 0; i < DEPTH; i++) model[i] = 0;

    // R1: reset state and fill lap
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(vid_valid), 0);
    check("R1 ack in reset", int'(wr_ack), 0);
    rst_n = 1'b1;
    n = 0; acks = 0;
    while (n < 3000) begin
      @(negedge clk);
      n++;
      if (wr_ack) acks++;
      if (vid_valid) break;
    end
    check("R1 fill lap length", n, DEPTH);
    check("R1 ack during fill", acks, 0);
    grab_frame();
    count_diffs(n);
    check("R1 blank frame", n, 0);
    check("R2 row flags", sor_seen, ROWS);
    check("R2 flag positions", sor_wrong, 0);

    // table walk: R4 accepted writes, R5 dropped ones
    for (int v = 0; v < NVEC; v++) begin
      do_write(int'(VEC[v][17:13]), int'(VEC[v][12:6]), int'(VEC[v][5:0]), got, lat);
      if (VEC[v][18]) begin
        check($sformatf("R4 ack vec%0d", v), got, 1);
        check($sformatf("R4 latency vec%0d", v), int'(lat <= 1802), 1);
        model[int'(VEC[v][17:13]) * COLS + int'(VEC[v][12:6])] = int'(VEC[v][5:0]);
      end else begin
        check($sformatf("R5 no ack vec%0d", v), got, 0);
      end
    end
    grab_frame();
    for (int v = 0; v < NVEC; v++)
      if (VEC[v][18])
        check($sformatf("R4 cell vec%0d", v),
              shot[int'(VEC[v][17:13]) * COLS + int'(VEC[v][12:6])], int'(VEC[v][5:0]));
    count_diffs(n);
    check("R5 frame unchanged elsewhere", n, 0);
    check("R2 row flags after writes", sor_wrong, 0);
    repeat (500) @(negedge clk);
    grab_frame();
    count_diffs(n);
    check("R3 retained next frame", n, 0);

    // R6: second request while the first is waiting
    @(negedge clk);
    wr_req = 1'b1; wr_row = 5'd5; wr_col = 7'd5; wr_code = 6'd9;
    @(negedge clk);
    wr_row = 5'd6; wr_col = 7'd6; wr_code = 6'd10;
    @(negedge clk);
    wr_req = 1'b0;
    acks = 0;
    repeat (3700) begin
      if (wr_ack) acks++;
      @(negedge clk);
    end
    check("R6 single ack", acks, 1);
    model[5 * COLS + 5] = 9;
    grab_frame();
    check("R6 first cell", shot[5 * COLS + 5], 9);
    check("R6 dropped cell", shot[6 * COLS + 6], 0);
    count_diffs(n);
    check("R6 frame", n, 0);

    // R7: scroll
    for (int i = 0; i < DEPTH; i++) prev[i] = model[i];
    @(negedge clk);
    scroll_req = 1'b1;
    @(negedge clk);
    scroll_req = 1'b0;
    n = 0;
    while (vid_valid && n < 4000) begin @(negedge clk); n++; end
    n = 0;
    while (!vid_valid && n < 200) begin @(negedge clk); n++; end
    check("R7 pause length", n, COLS);
    check("R7 sof after pause", int'(vid_sof), 1);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        model[r * COLS + c] = prev[((r + 1) % ROWS) * COLS + c];
    grab_frame();
    count_diffs(n);
    check("R7 rows moved up", n, 0);
    check("R7 first char", shot[0], 6);
    check("R7 wrapped row", shot[24 * COLS], 1);
    check("R2 row flags after scroll", sor_seen, ROWS);

    // R8: coordinates follow the shown screen
    do_write(0, 0, 11, got, lat);
    check("R8 ack", got, 1);
    model[0] = 11;
    grab_frame();
    check("R8 top-left", shot[0], 11);
    check("R8 bottom row kept", shot[24 * COLS], 1);
    count_diffs(n);
    check("R8 frame", n, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule